// File: doc/BRIEF.md
# Per-Channel Spectrum Accumulator

This block turns a stream of digitised pulse heights into one energy spectrum per input channel. Each conversion arrives as a channel number and a pulse-height value. The block treats the value as a bin index in that channel's bank and adds one to the bin with a read, add, write sequence. Each bin is a saturating occurrence counter. When a counter runs out of range, only its own channel stops acquiring. Conversions for that channel are then dropped and counted until software clears the channel's flags.

A small command port lets software work on the block while it is idle. Software can clear the flags of a set of channels, read a bin, read a channel's rejected-conversion count, or zero a whole bank. Zeroing writes one address per cycle and holds off all other traffic. A single data-ready output summarises the per-channel flags. The bank memories are behavioural models with one registered read port and one write port each. After reset their contents are undefined, so software zeroes every bank before it starts acquiring.

The channel count, bin index width, counter width and rejected-counter width are parameters. The full-size configuration is eight channels, 13-bit bins and 32-bit counters. The elaboration defaults use 8-bit bins to keep the behavioural memories small.

Top module: `hist_accum`

## Requirements
- R1: After reset, `in_ready` and `cmd_ready` are high, and `full_flags`, `half_flags`, `data_ready`, `rd_valid` and `clr_busy` are all low.
- R2: A conversion accepted on a channel that is not full adds exactly one to bin `in_value` of bank `in_chan`. Every other bin of every bank is left unchanged.
- R3: After a conversion is accepted on a channel that is not full, `in_ready` is low for exactly three cycles (read, add, write) and then returns high.
- R4: The half flag of a channel is set when an increment brings any of its bins to 2^(CNT_W-1) or above. It stays set until it is cleared by command.
- R5: An increment of a bin that already holds all ones leaves the bin at all ones, does not wrap it to zero, and sets that channel's full flag.
- R6: A conversion for a channel whose full flag is set is accepted without `in_ready` dropping. It changes no bin, and it adds one to that channel's rejected count, which saturates at 2^REJ_W-1.
- R7: A full flag on one channel does not stop acquisition, or change the flags or the rejected count, on any other channel.
- R8: Command op 0 clears the full flag, the half flag and the rejected count of every channel whose bit is set in `cmd_mask`. All other channels keep their state.
- R9: Command op 1 returns the selected bin with `rd_valid` high for one cycle, two cycles after the command is accepted. Command op 2 returns the selected channel's rejected count, zero-extended, one cycle after the command is accepted.
- R10: Command op 3 writes zero to every bin of the selected bank, one bin per cycle. `clr_busy` is high for exactly 2^VAL_W cycles, `in_ready` and `cmd_ready` are low during that time, and the other banks are left unchanged.
- R11: `data_ready` is high exactly when at least one full or half flag is set.
- R12: While `cmd_valid` is high, `in_ready` is low, so a command offered in the same idle cycle as a conversion is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion offered |
| in_chan | input | CH_W | Channel of the conversion |
| in_value | input | VAL_W | Pulse-height value, used as the bin index |
| in_ready | output | 1 | Conversion accepted at this edge if `in_valid` is high |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 clear flags, 1 read bin, 2 read rejected count, 3 zero bank |
| cmd_chan | input | CH_W | Channel selected by ops 1, 2 and 3 |
| cmd_bin | input | VAL_W | Bin selected by op 1 |
| cmd_mask | input | NUM_CH | Channels selected by op 0 |
| cmd_ready | output | 1 | Command accepted at this edge if `cmd_valid` is high |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | CNT_W | Read result |
| full_flags | output | NUM_CH | Per-channel overflow (halt) flags |
| half_flags | output | NUM_CH | Per-channel half-scale flags |
| data_ready | output | 1 | Summary of all flags |
| clr_busy | output | 1 | Bank zeroing in progress |

## Verification
The bench builds the block with four channels, 3-bit bins, 4-bit counters and 4-bit rejected counters. With this configuration every bin of every bank can be read back after each phase. The half-scale point (8) and the saturation point (15) are reached within a few dozen conversions. The rejected counter can be driven through its own saturation at 15. A bank clear covers only eight cycles, so its busy length can be counted exactly. Saturation, the per-channel halt and the selective flag clearing can all be exercised against an arithmetic model in a short run.

// File: rtl/hist_pkg.sv
package hist_pkg;

   typedef enum logic [1:0] {
      OP_CLR_FLAGS = 2'd0,
      OP_READ_BIN  = 2'd1,
      OP_READ_REJ  = 2'd2,
      OP_ZERO_BANK = 2'd3
   } hist_op_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_ADD    = 3'd2,
      ST_WRITE  = 3'd3,
      ST_FETCH  = 3'd4,
      ST_RETURN = 3'd5,
      ST_ZERO   = 3'd6
   } hist_state_e;

endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_addr];
   end

endmodule

// File: rtl/hist_flags.sv
module hist_flags #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int REJ_W  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CH_W-1:0]               evt_ch,
   input  logic                          ovf_pulse,
   input  logic                          half_pulse,
   input  logic                          drop_pulse,
   input  logic [CH_W-1:0]               drop_ch,
   input  logic                          clr_pulse,
   input  logic [NUM_CH-1:0]             clr_mask,
   output logic [NUM_CH-1:0]             full,
   output logic [NUM_CH-1:0]             half,
   output logic [NUM_CH-1:0][REJ_W-1:0]  rej_cnt
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit_evt, hit_drop;
      assign hit_evt  = (evt_ch == CH_W'(i));
      assign hit_drop = drop_pulse && (drop_ch == CH_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full[i]    <= 1'b0;
            half[i]    <= 1'b0;
            rej_cnt[i] <= '0;
         end else if (clr_pulse && clr_mask[i]) begin
            full[i]    <= 1'b0;
            half[i]    <= 1'b0;
            rej_cnt[i] <= '0;
         end else begin
            if (ovf_pulse && hit_evt)  full[i] <= 1'b1;
            if (half_pulse && hit_evt) half[i] <= 1'b1;
            if (hit_drop && !(&rej_cnt[i])) rej_cnt[i] <= rej_cnt[i] + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hist_seq.sv
module hist_seq
   import hist_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int VAL_W  = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [VAL_W-1:0]  in_value,
   output logic              in_ready,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [CH_W-1:0]   cmd_chan,
   input  logic [VAL_W-1:0]  cmd_bin,
   output logic              cmd_ready,
   input  logic [NUM_CH-1:0] full_vec,
   input  logic [CNT_W-1:0]  rd_word,
   output logic [CH_W-1:0]   mem_ch,
   output logic [VAL_W-1:0]  mem_addr,
   output logic              mem_rd,
   output logic              mem_we,
   output logic [CNT_W-1:0]  mem_wdata,
   output logic              ovf_pulse,
   output logic              half_pulse,
   output logic              drop_pulse,
   output logic              clr_pulse,
   output logic              clr_busy,
   output logic              rd_valid,
   output logic              rd_src_rej
);

   hist_state_e       state;
   logic [CH_W-1:0]   ch_q;
   logic [VAL_W-1:0]  bin_q;
   logic [VAL_W-1:0]  zaddr;
   logic [CNT_W-1:0]  sum_q;
   logic              sat_q;
   logic              src_rej_q;
   logic              idle, take_cmd, take_in, halted;
   hist_op_e          op;

   assign op       = hist_op_e'(cmd_op);
   assign idle     = (state == ST_IDLE);
   assign take_cmd = idle && cmd_valid;
   assign take_in  = idle && !cmd_valid && in_valid;
   assign halted   = full_vec[in_chan];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ch_q      <= '0;
         bin_q     <= '0;
         zaddr     <= '0;
         sum_q     <= '0;
         sat_q     <= 1'b0;
         src_rej_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take_cmd) begin
                  ch_q  <= cmd_chan;
                  bin_q <= cmd_bin;
                  unique case (op)
                     OP_CLR_FLAGS: state <= ST_IDLE;
                     OP_READ_BIN: begin
                        src_rej_q <= 1'b0;
                        state     <= ST_FETCH;
                     end
                     OP_READ_REJ: begin
                        src_rej_q <= 1'b1;
                        state     <= ST_RETURN;
                     end
                     OP_ZERO_BANK: begin
                        zaddr <= '0;
                        state <= ST_ZERO;
                     end
                  endcase
               end else if (take_in && !halted) begin
                  ch_q  <= in_chan;
                  bin_q <= in_value;
                  state <= ST_READ;
               end
            end
            ST_READ:  state <= ST_ADD;
            ST_ADD: begin
               sat_q <= &rd_word;
               sum_q <= (&rd_word) ? rd_word : rd_word + 1'b1;
               state <= ST_WRITE;
            end
            ST_WRITE:  state <= ST_IDLE;
            ST_FETCH:  state <= ST_RETURN;
            ST_RETURN: state <= ST_IDLE;
            ST_ZERO: begin
               zaddr <= zaddr + 1'b1;
               if (&zaddr) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready   = idle && !cmd_valid;
   assign cmd_ready  = idle;
   assign mem_ch     = ch_q;
   assign mem_addr   = (state == ST_ZERO) ? zaddr : bin_q;
   assign mem_rd     = (state == ST_READ) || (state == ST_FETCH);
   assign mem_we     = (state == ST_WRITE) || (state == ST_ZERO);
   assign mem_wdata  = (state == ST_ZERO) ? '0 : sum_q;
   assign ovf_pulse  = (state == ST_WRITE) && sat_q;
   assign half_pulse = (state == ST_WRITE) && sum_q[CNT_W-1];
   assign drop_pulse = take_in && halted;
   assign clr_pulse  = take_cmd && (op == OP_CLR_FLAGS);
   assign clr_busy   = (state == ST_ZERO);
   assign rd_valid   = (state == ST_RETURN);
   assign rd_src_rej = src_rej_q;

endmodule

// File: rtl/hist_accum.sv
module hist_accum #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = $clog2(NUM_CH),
   parameter int VAL_W  = 8,
   parameter int CNT_W  = 32,
   parameter int REJ_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [VAL_W-1:0]  in_value,
   output logic              in_ready,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [CH_W-1:0]   cmd_chan,
   input  logic [VAL_W-1:0]  cmd_bin,
   input  logic [NUM_CH-1:0] cmd_mask,
   output logic              cmd_ready,
   output logic              rd_valid,
   output logic [CNT_W-1:0]  rd_data,
   output logic [NUM_CH-1:0] full_flags,
   output logic [NUM_CH-1:0] half_flags,
   output logic              data_ready,
   output logic              clr_busy
);

   initial begin
      assert (NUM_CH >= 2 && (1 << CH_W) == NUM_CH)
         else $fatal(1, "NUM_CH must be a power of two, at least 2, matching CH_W");
      assert (VAL_W >= 1 && VAL_W <= 16) else $fatal(1, "VAL_W out of range");
      assert (CNT_W >= 2 && CNT_W <= 64) else $fatal(1, "CNT_W out of range");
      assert (REJ_W >= 1 && REJ_W <= CNT_W) else $fatal(1, "REJ_W must fit in CNT_W");
   end

   logic [CH_W-1:0]               mem_ch;
   logic [VAL_W-1:0]              mem_addr;
   logic                          mem_rd, mem_we;
   logic [CNT_W-1:0]              mem_wdata;
   logic [CNT_W-1:0]              rd_word;
   logic [NUM_CH-1:0][CNT_W-1:0]  bank_q;
   logic [NUM_CH-1:0][REJ_W-1:0]  rej_cnt;
   logic                          ovf_pulse, half_pulse, drop_pulse, clr_pulse;
   logic                          rd_src_rej;
   logic [CNT_W-1:0]              rej_ext;

   hist_seq #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .VAL_W(VAL_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_chan    (in_chan),
      .in_value   (in_value),
      .in_ready   (in_ready),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_chan   (cmd_chan),
      .cmd_bin    (cmd_bin),
      .cmd_ready  (cmd_ready),
      .full_vec   (full_flags),
      .rd_word    (rd_word),
      .mem_ch     (mem_ch),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .ovf_pulse  (ovf_pulse),
      .half_pulse (half_pulse),
      .drop_pulse (drop_pulse),
      .clr_pulse  (clr_pulse),
      .clr_busy   (clr_busy),
      .rd_valid   (rd_valid),
      .rd_src_rej (rd_src_rej)
   );

   for (genvar b = 0; b < NUM_CH; b++) begin : g_bank
      logic sel;
      assign sel = (mem_ch == CH_W'(b));
      hist_bank #(.ADDR_W(VAL_W), .DATA_W(CNT_W)) u_bank (
         .clk     (clk),
         .rd_en   (mem_rd && sel),
         .rd_addr (mem_addr),
         .rd_data (bank_q[b]),
         .wr_en   (mem_we && sel),
         .wr_addr (mem_addr),
         .wr_data (mem_wdata)
      );
   end

   assign rd_word = bank_q[mem_ch];

   hist_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W), .REJ_W(REJ_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_ch     (mem_ch),
      .ovf_pulse  (ovf_pulse),
      .half_pulse (half_pulse),
      .drop_pulse (drop_pulse),
      .drop_ch    (in_chan),
      .clr_pulse  (clr_pulse),
      .clr_mask   (cmd_mask),
      .full       (full_flags),
      .half       (half_flags),
      .rej_cnt    (rej_cnt)
   );

   always_comb begin
      rej_ext = '0;
      rej_ext[REJ_W-1:0] = rej_cnt[mem_ch];
   end

   assign rd_data    = rd_src_rej ? rej_ext : rd_word;
   assign data_ready = (|full_flags) || (|half_flags);

endmodule

// File: rtl/hist_accum_chk.sv
module hist_accum_chk #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int VAL_W  = 8,
   parameter int CNT_W  = 32,
   parameter int REJ_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [CH_W-1:0]   in_chan,
   input logic [VAL_W-1:0]  in_value,
   input logic              in_ready,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [CH_W-1:0]   cmd_chan,
   input logic [VAL_W-1:0]  cmd_bin,
   input logic [NUM_CH-1:0] cmd_mask,
   input logic              cmd_ready,
   input logic              rd_valid,
   input logic [CNT_W-1:0]  rd_data,
   input logic [NUM_CH-1:0] full_flags,
   input logic [NUM_CH-1:0] half_flags,
   input logic              data_ready,
   input logic              clr_busy
);

   // R3: a conversion on a live channel blocks input for three cycles
   a_r3_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !full_flags[in_chan])
      |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 cmd_ready);

   // R6: a dropped conversion does not make the block busy
   a_r6_drop_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && full_flags[in_chan]) |=> cmd_ready);

   // R9: a bin read returns two cycles after acceptance
   a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_op == 2'd1) |=> !rd_valid ##1 rd_valid);

   // R10: bank zeroing holds off both ports
   a_r10_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |-> (!in_ready && !cmd_ready));

   // R11: any full flag raises data-ready
   a_r11_ready_out: assert property (@(posedge clk) disable iff (!rst_n)
      (|full_flags) |-> data_ready);

   // R12: an offered command blocks conversions
   a_r12_cmd_first: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !in_ready);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sticky
      // R8: a full flag only goes away through a masked clear command
      a_r8_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (full_flags[i] && !(cmd_valid && cmd_ready && cmd_op == 2'd0 && cmd_mask[i]))
         |=> full_flags[i]);
   end

endmodule

bind hist_accum hist_accum_chk #(
   .NUM_CH(NUM_CH), .CH_W(CH_W), .VAL_W(VAL_W), .CNT_W(CNT_W), .REJ_W(REJ_W)
) u_chk (.*);

// File: tb/hist_accum_test.sv
module hist_accum_test;
   localparam int NCH  = 4;
   localparam int CHW  = 2;
   localparam int VW   = 3;
   localparam int CW   = 4;
   localparam int RW   = 4;
   localparam int NBIN = 1 << VW;
   localparam int CMAX = (1 << CW) - 1;
   localparam int HALF = 1 << (CW - 1);
   localparam int RMAX = (1 << RW) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [CHW-1:0] in_chan = '0;
   logic [VW-1:0]  in_value = '0;
   logic           in_ready;
   logic           cmd_valid = 1'b0;
   logic [1:0]     cmd_op = '0;
   logic [CHW-1:0] cmd_chan = '0;
   logic [VW-1:0]  cmd_bin = '0;
   logic [NCH-1:0] cmd_mask = '0;
   logic           cmd_ready, rd_valid, data_ready, clr_busy;
   logic [CW-1:0]  rd_data;
   logic [NCH-1:0] full_flags, half_flags;

   int checks = 0;
   int errors = 0;
   int mdl [NCH][NBIN];
   bit mfull [NCH];
   bit mhalf [NCH];
   int mrej [NCH];

   always #4 clk = ~clk;

   hist_accum #(.NUM_CH(NCH), .CH_W(CHW), .VAL_W(VW), .CNT_W(CW), .REJ_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_value(in_value), .in_ready(in_ready), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_bin(cmd_bin), .cmd_mask(cmd_mask),
      .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .full_flags(full_flags), .half_flags(half_flags), .data_ready(data_ready),
      .clr_busy(clr_busy));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model_push(input int ch, input int v);
      if (mfull[ch]) begin
         if (mrej[ch] < RMAX) mrej[ch]++;
      end else if (mdl[ch][v] == CMAX) begin
         mfull[ch] = 1'b1;
      end else begin
         mdl[ch][v]++;
         if (mdl[ch][v] >= HALF) mhalf[ch] = 1'b1;
      end
   endfunction

   task automatic push(input int ch, input int v);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_chan = CHW'(ch); in_value = VW'(v);
      @(negedge clk);
      in_valid = 1'b0;
      while (!cmd_ready) @(negedge clk);
      model_push(ch, v);
   endtask

   task automatic do_cmd(input int op, input int ch, input int bin, input int mask);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_chan = CHW'(ch);
      cmd_bin = VW'(bin); cmd_mask = NCH'(mask);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_bin(input int ch, input int bin, output int val);
      do_cmd(1, ch, bin, 0);
      @(negedge clk);
      chk(rd_valid === 1'b1, "R9 bin read valid", int'(rd_valid), 1);
      val = int'(rd_data);
   endtask

   task automatic read_rej(input int ch, output int val);
      do_cmd(2, ch, 0, 0);
      chk(rd_valid === 1'b1, "R9 reject read valid", int'(rd_valid), 1);
      val = int'(rd_data);
   endtask

   task automatic zero_bank(input int ch);
      int n = 0;
      do_cmd(3, ch, 0, 0);
      while (clr_busy) begin
         chk(!in_ready && !cmd_ready, "R10 ports held while zeroing",
             int'({in_ready, cmd_ready}), 0);
         n++;
         @(negedge clk);
      end
      chk(n == NBIN, "R10 zeroing length", n, NBIN);
      for (int b = 0; b < NBIN; b++) mdl[ch][b] = 0;
   endtask

   task automatic check_flags();
      for (int c = 0; c < NCH; c++) begin
         chk(full_flags[c] == mfull[c], "R5 R7 full flag", int'(full_flags[c]), int'(mfull[c]));
         chk(half_flags[c] == mhalf[c], "R4 half flag", int'(half_flags[c]), int'(mhalf[c]));
      end
      chk(data_ready == ((|full_flags) || (|half_flags)) &&
          data_ready == (mfull.or() || mhalf.or()), "R11 data ready",
          int'(data_ready), int'(mfull.or() || mhalf.or()));
   endtask

   task automatic compare_all(input string req);
      int v;
      for (int c = 0; c < NCH; c++) begin
         for (int b = 0; b < NBIN; b++) begin
            read_bin(c, b, v);
            chk(v == mdl[c][b], req, v, mdl[c][b]);
         end
         read_rej(c, v);
         chk(v == mrej[c], "R6 rejected count", v, mrej[c]);
      end
      check_flags();
   endtask

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, gap;
      for (int c = 0; c < NCH; c++) begin
         mfull[c] = 1'b0; mhalf[c] = 1'b0; mrej[c] = 0;
         for (int b = 0; b < NBIN; b++) mdl[c][b] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready && cmd_ready, "R1 ready after reset", int'({in_ready, cmd_ready}), 3);
      chk(full_flags == '0 && half_flags == '0, "R1 flags after reset",
          int'({full_flags, half_flags}), 0);
      chk(!data_ready && !rd_valid && !clr_busy, "R1 outputs after reset",
          int'({data_ready, rd_valid, clr_busy}), 0);

      // R10 zero every bank, then everything reads zero
      for (int c = 0; c < NCH; c++) zero_bank(c);
      compare_all("R10 bank zeroed");

      // R3 input gap after an accepted conversion
      @(negedge clk);
      in_valid = 1'b1; in_chan = 2'd0; in_value = 3'd3;
      @(negedge clk);
      in_valid = 1'b0;
      gap = 0;
      while (!in_ready && gap < 10) begin gap++; @(negedge clk); end
      chk(gap == 3, "R3 input gap", gap, 3);
      model_push(0, 3);

      // R2 sweep: every bin of every channel gets its own count
      for (int c = 0; c < NCH; c++)
         for (int b = 0; b < NBIN; b++)
            for (int k = 0; k < (c + b) % 4 + 1; k++) push(c, b);
      compare_all("R2 bin counts after sweep");

      // R4 half scale on channel 1 bin 2
      while (mdl[1][2] < HALF) push(1, 2);
      check_flags();
      chk(half_flags[1] === 1'b1, "R4 half set at half scale", int'(half_flags[1]), 1);

      // R5 saturation on channel 2 bin 5
      while (mdl[2][5] < CMAX) push(2, 5);
      chk(full_flags[2] === 1'b0, "R5 no full at top value", int'(full_flags[2]), 0);
      push(2, 5);
      chk(full_flags[2] === 1'b1, "R5 full on overflow", int'(full_flags[2]), 1);
      read_bin(2, 5, v);
      chk(v == CMAX, "R5 saturated not wrapped", v, CMAX);

      // R6 drops on the halted channel, no busy, saturating count
      @(negedge clk);
      in_valid = 1'b1; in_chan = 2'd2; in_value = 3'd0;
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready === 1'b1, "R6 no busy on drop", int'(in_ready), 1);
      model_push(2, 0);
      for (int k = 0; k < RMAX + 2; k++) push(2, k % NBIN);
      read_rej(2, v);
      chk(v == RMAX, "R6 reject count saturates", v, RMAX);

      // R7 other channels still acquire
      push(3, 0);
      push(0, 7);
      compare_all("R7 other channels unaffected");

      // R12 command wins over a conversion offered together
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_chan = 2'd2;
      in_valid = 1'b1; in_chan = 2'd0; in_value = 3'd1;
      #1;
      chk(in_ready === 1'b0, "R12 input held while command offered", int'(in_ready), 1'b0);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(rd_valid === 1'b1 && int'(rd_data) == RMAX, "R12 command served first",
          int'(rd_data), RMAX);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      while (!cmd_ready) @(negedge clk);
      model_push(0, 1);

      // R8 selective clear of channel 2 only
      do_cmd(0, 0, 0, 4'b0100);
      mfull[2] = 1'b0; mhalf[2] = 1'b0; mrej[2] = 0;
      compare_all("R8 clear keeps bins");
      chk(half_flags[1] === 1'b1, "R8 unmasked half kept", int'(half_flags[1]), 1);
      push(2, 5);
      chk(full_flags[2] === 1'b1, "R8 R5 full again after clear", int'(full_flags[2]), 1);
      do_cmd(0, 0, 0, 4'b0110);
      mfull[2] = 1'b0; mhalf[2] = 1'b0; mrej[2] = 0; mfull[1] = 1'b0; mhalf[1] = 1'b0;
      @(negedge clk);
      check_flags();
      chk(data_ready === 1'b0, "R11 data ready drops when all clear", int'(data_ready), 0);

      // R10 zero channel 1 only
      zero_bank(1);
      compare_all("R10 one bank zeroed, others kept");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule